// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Register

This block holds the normal interrupt status of an SD host controller. It watches four level signals from the present-state logic: card present, buffer read allowed, buffer write allowed and data line busy. It also watches single-cycle strobes from the transfer engine. Selected edges of the levels and qualified strobes are turned into sticky status bits. Software clears a bit by writing 1 to its position.

A per-bit status-enable vector decides which events may latch. A separate signal-enable vector decides which latched bits drive the single host interrupt line. The card interrupt bit differs from the rest. It is a registered copy of the card's interrupt request. Software cannot clear it by a write. It is forced to 0 while its status-enable bit is 0 and follows the request again once the enable returns to 1.

Bit positions in `status_o` and `wr_data_i`:

| Bit | Meaning |
|-----|---------|
| 0 | command complete |
| 1 | transfer complete |
| 2 | block gap event |
| 3 | DMA boundary |
| 4 | buffer write ready |
| 5 | buffer read ready |
| 6 | card insertion |
| 7 | card removal |
| 8 | card interrupt |

Top module: `sd_int_status`

## Requirements
- R1: When reset is asserted, `status_o` reads all zero and `irq_o` is 0.
- R2: Bit 6 sets after a 0-to-1 change of `card_in_i`. Bit 7 sets after a 1-to-0 change of `card_in_i`.
- R3: Bit 5 sets after a 0-to-1 change of `buf_rd_en_i`. Bit 4 sets after a 0-to-1 change of `buf_wr_en_i`. A falling edge of either input sets nothing.
- R4: Bit 3 sets on a `dma_bound_i` strobe only while a transfer is running. A transfer starts with `xfer_start_i` and ends with `xfer_done_i`. A strobe that comes together with `xfer_done_i`, or after it, is ignored.
- R5: Bit 2 sets only while `stop_gap_req_i` is 1. For a read (`xfer_rd_i`=1) it sets on a 1-to-0 change of `dat_active_i`. For a write (`xfer_rd_i`=0) it sets on a `gap_stop_i` strobe.
- R6: Bit 0 sets on a `cmd_done_i` strobe. Bit 1 sets on an `xfer_done_i` strobe.
- R7: A cycle with `wr_en_i`=1 clears each of bits 0 to 7 whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R8: If a set event and a write-1 clear reach the same bit in the same cycle, the bit ends up as 1.
- R9: An event sets a bit among 0 to 7 only if the matching `stat_en_i` bit is 1. Clearing an enable bit does not clear an already latched bit among 0 to 7.
- R10: Bit 8 equals `card_irq_i & stat_en_i[8]` as sampled at the previous clock edge. Writes to bit 8 have no effect.
- R11: `irq_o` is 1 exactly when some bit of `status_o & sig_en_i` is 1.
- R12: A level input that is already 1 when reset is released produces no edge event.
- R13: Every status update takes effect at the first clock edge that samples the cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| card_in_i | input | 1 | card present level, already synchronous and debounced |
| buf_rd_en_i | input | 1 | buffer can be read |
| buf_wr_en_i | input | 1 | buffer can be written |
| dat_active_i | input | 1 | data line busy level |
| card_irq_i | input | 1 | interrupt request level from the card |
| cmd_done_i | input | 1 | command finished strobe |
| xfer_start_i | input | 1 | transfer begins strobe |
| xfer_done_i | input | 1 | transfer finished strobe |
| dma_bound_i | input | 1 | DMA buffer boundary reached strobe |
| gap_stop_i | input | 1 | write transfer halted at a block gap strobe |
| xfer_rd_i | input | 1 | 1 = current transfer is a read |
| stop_gap_req_i | input | 1 | software asks the transfer to halt at the next gap |
| wr_en_i | input | 1 | write strobe for the clear operation |
| wr_data_i | input | 9 | write-1-to-clear mask, bit layout as `status_o` |
| stat_en_i | input | 9 | per-bit status enable |
| sig_en_i | input | 9 | per-bit interrupt signal enable |
| status_o | output | 9 | status bits, layout in the table above |
| irq_o | output | 1 | interrupt to the host |

## Verification
A wrong edge-history register or a wrong transfer-running flag shows up as a status bit that is set or missing one clock after the offending input change. The host interrupt line shows the same fault in the same cycle whenever that bit's signal enable is 1. A fault in the clear path can stay hidden until software writes a 1 or a set and a clear collide. The stimulus therefore mixes random writes with event strobes so that these collisions occur often. Every output is compared against a cycle model at every clock.

// File: rtl/sdis_pkg.sv
package sdis_pkg;
  localparam int STAT_W   = 9;
  localparam int LVL_W    = 4;
  localparam int STICKY_W = 8;
  // status bit positions
  localparam int B_CMD  = 0;
  localparam int B_XFER = 1;
  localparam int B_GAP  = 2;
  localparam int B_DMA  = 3;
  localparam int B_WRDY = 4;
  localparam int B_RRDY = 5;
  localparam int B_INS  = 6;
  localparam int B_REM  = 7;
  localparam int B_CARD = 8;
  // level input positions
  localparam int L_CARD = 0;
  localparam int L_RD   = 1;
  localparam int L_WR   = 2;
  localparam int L_DAT  = 3;
endpackage

// File: rtl/sdis_edge.sv
module sdis_edge #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  // history is invalid until the first edge after reset (R12)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= 1'b1;
    end
  end

  assign rise_o = lvl_i & ~prev_q & {W{armed_q}};
  assign fall_o = ~lvl_i & prev_q & {W{armed_q}};
endmodule

// File: rtl/sdis_sticky.sv
module sdis_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic set_ok;

  assign set_ok = set_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_ok) q_q <= 1'b1;  // set beats clear
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;

  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_ok) |=> !q_o);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ok |=> q_o);
  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_ok && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/sd_int_status.sv
module sd_int_status
  import sdis_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_in_i,
  input  logic              buf_rd_en_i,
  input  logic              buf_wr_en_i,
  input  logic              dat_active_i,
  input  logic              card_irq_i,
  input  logic              cmd_done_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  input  logic              dma_bound_i,
  input  logic              gap_stop_i,
  input  logic              xfer_rd_i,
  input  logic              stop_gap_req_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] stat_en_i,
  input  logic [STAT_W-1:0] sig_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [LVL_W-1:0]    lvl, rise, fall;
  logic [STICKY_W-1:0] set_vec, clr_vec, sticky_q;
  logic                busy_q;
  logic                card_q;

  assign lvl[L_CARD] = card_in_i;
  assign lvl[L_RD]   = buf_rd_en_i;
  assign lvl[L_WR]   = buf_wr_en_i;
  assign lvl[L_DAT]  = dat_active_i;

  sdis_edge #(.W(LVL_W)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  // transfer running window for DMA qualification
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= xfer_start_i | (busy_q & ~xfer_done_i);
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_CMD]  = cmd_done_i;
    set_vec[B_XFER] = xfer_done_i;
    set_vec[B_GAP]  = stop_gap_req_i & (xfer_rd_i ? fall[L_DAT] : gap_stop_i);
    set_vec[B_DMA]  = dma_bound_i & busy_q & ~xfer_done_i;
    set_vec[B_WRDY] = rise[L_WR];
    set_vec[B_RRDY] = rise[L_RD];
    set_vec[B_INS]  = rise[L_CARD];
    set_vec[B_REM]  = fall[L_CARD];
  end

  assign clr_vec = wr_data_i[STICKY_W-1:0] & {STICKY_W{wr_en_i}};

  for (genvar b = 0; b < STICKY_W; b++) begin : g_bit
    sdis_sticky u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[b]),
      .en_i  (stat_en_i[b]),
      .clr_i (clr_vec[b]),
      .q_o   (sticky_q[b])
    );
  end

  // card interrupt: sampled level, dropping the enable flushes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) card_q <= 1'b0;
    else         card_q <= card_irq_i & stat_en_i[B_CARD];
  end

  assign status_o = {card_q, sticky_q};
  assign irq_o    = |(status_o & sig_en_i);

  a_r10_card_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[B_CARD] == $past(card_irq_i & stat_en_i[B_CARD]));
  a_r4_dma_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !status_o[B_DMA]) |=> !status_o[B_DMA]);
  a_r5_gap_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_gap_req_i && !status_o[B_GAP]) |=> !status_o[B_GAP]);
  a_r2_ins_rem_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[B_INS] && !status_o[B_REM]) |=> !(status_o[B_INS] && status_o[B_REM]));
endmodule

// File: tb/sim_sd_int_status.sv
module sim_sd_int_status;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic card_in_i, buf_rd_en_i, buf_wr_en_i, dat_active_i, card_irq_i;
  logic cmd_done_i, xfer_start_i, xfer_done_i, dma_bound_i, gap_stop_i;
  logic xfer_rd_i, stop_gap_req_i, wr_en_i;
  logic [8:0] wr_data_i, stat_en_i, sig_en_i, status_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [8:0] m_stat;
  logic [3:0] m_prev;
  logic       m_armed, m_busy;

  always #2 clk_i = ~clk_i;

  sd_int_status u0 (.*);

  function automatic string tag_of(int b);
    case (b)
      0, 1:    return "R6";
      2:       return "R5";
      3:       return "R4";
      4, 5:    return "R3";
      6, 7:    return "R2";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat = '0; m_prev = '0; m_armed = 0; m_busy = 0;
    end else begin
      logic [3:0] lv, ri, fa;
      logic [7:0] st, cl;
      lv = {dat_active_i, buf_wr_en_i, buf_rd_en_i, card_in_i};
      ri = lv & ~m_prev & {4{m_armed}};
      fa = ~lv & m_prev & {4{m_armed}};
      st[0] = cmd_done_i;
      st[1] = xfer_done_i;
      st[2] = stop_gap_req_i & (xfer_rd_i ? fa[3] : gap_stop_i);
      st[3] = dma_bound_i & m_busy & ~xfer_done_i;
      st[4] = ri[2];
      st[5] = ri[1];
      st[6] = ri[0];
      st[7] = fa[0];
      cl = wr_en_i ? wr_data_i[7:0] : 8'h00;
      for (int b = 0; b < 8; b++) begin
        if (stat_en_i[b] && st[b]) m_stat[b] = 1'b1;
        else if (cl[b])            m_stat[b] = 1'b0;
      end
      m_stat[8] = card_irq_i & stat_en_i[8];
      m_busy  = xfer_start_i | (m_busy & ~xfer_done_i);
      m_prev  = lv;
      m_armed = 1'b1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    for (int b = 0; b < 9; b++)
      chk(tag_of(b), 32'(status_o[b]), 32'(m_stat[b]));
    chk("R11", 32'(irq_o), 32'(|(m_stat & sig_en_i)));
  endtask

  // one clock: compare on the falling edge, then drop strobes
  task automatic tick();
    @(negedge clk_i);
    cmp_model();
    cmd_done_i = 0; xfer_start_i = 0; xfer_done_i = 0; dma_bound_i = 0;
    gap_stop_i = 0; wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic w1c(logic [8:0] m);
    wr_en_i = 1; wr_data_i = m;
  endtask

  initial begin
    card_in_i = 1; buf_rd_en_i = 0; buf_wr_en_i = 0; dat_active_i = 0;
    card_irq_i = 0; cmd_done_i = 0; xfer_start_i = 0; xfer_done_i = 0;
    dma_bound_i = 0; gap_stop_i = 0; xfer_rd_i = 1; stop_gap_req_i = 0;
    wr_en_i = 0; wr_data_i = '0; stat_en_i = '1; sig_en_i = '0;
    void'($urandom(32'h5D1A7));
    repeat (3) @(negedge clk_i);
    chk("R1", 32'(status_o), 0);
    chk("R1", 32'(irq_o), 0);
    rst_ni = 1;
    repeat (3) tick();
    chk("R12", 32'(status_o), 0);

    card_in_i = 0; tick();
    chk("R2", 32'(status_o[7]), 1);
    chk("R13", 32'(irq_o), 0);
    sig_en_i = 9'h080; tick();
    chk("R11", 32'(irq_o), 1);
    w1c(9'h07F); tick();
    chk("R7", 32'(status_o[7]), 1);
    w1c(9'h080); tick();
    chk("R7", 32'(status_o[7]), 0);
    card_in_i = 1; tick();
    chk("R2", 32'(status_o[6]), 1);

    cmd_done_i = 1; w1c(9'h001); tick();
    chk("R8", 32'(status_o[0]), 1);

    dma_bound_i = 1; tick();
    chk("R4", 32'(status_o[3]), 0);
    xfer_start_i = 1; tick();
    dma_bound_i = 1; tick();
    chk("R4", 32'(status_o[3]), 1);
    w1c(9'h008); tick();
    dma_bound_i = 1; xfer_done_i = 1; tick();
    chk("R4", 32'(status_o[3]), 0);
    chk("R6", 32'(status_o[1]), 1);
    dma_bound_i = 1; tick();
    chk("R4", 32'(status_o[3]), 0);

    dat_active_i = 1; tick();
    dat_active_i = 0; tick();
    chk("R5", 32'(status_o[2]), 0);
    stop_gap_req_i = 1; dat_active_i = 1; tick();
    dat_active_i = 0; tick();
    chk("R5", 32'(status_o[2]), 1);
    w1c(9'h004); xfer_rd_i = 0; tick();
    gap_stop_i = 1; tick();
    chk("R5", 32'(status_o[2]), 1);
    stop_gap_req_i = 0;

    stat_en_i[5] = 0; buf_rd_en_i = 1; tick();
    chk("R9", 32'(status_o[5]), 0);
    stat_en_i[5] = 1; buf_rd_en_i = 0; tick();
    buf_rd_en_i = 1; buf_wr_en_i = 1; tick();
    chk("R3", 32'(status_o[5:4]), 3);
    stat_en_i[5] = 0; tick();
    chk("R9", 32'(status_o[5]), 1);
    stat_en_i[5] = 1;

    card_irq_i = 1; w1c(9'h100); tick();
    chk("R10", 32'(status_o[8]), 1);
    stat_en_i[8] = 0; tick();
    chk("R10", 32'(status_o[8]), 0);
    stat_en_i[8] = 1; tick();
    chk("R10", 32'(status_o[8]), 1);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) card_in_i    = ~card_in_i;
      if ($urandom_range(5) == 0) buf_rd_en_i  = ~buf_rd_en_i;
      if ($urandom_range(5) == 0) buf_wr_en_i  = ~buf_wr_en_i;
      if ($urandom_range(3) == 0) dat_active_i = ~dat_active_i;
      if ($urandom_range(9) == 0) card_irq_i   = ~card_irq_i;
      if ($urandom_range(15) == 0) xfer_rd_i   = ~xfer_rd_i;
      if ($urandom_range(7) == 0) stop_gap_req_i = ~stop_gap_req_i;
      cmd_done_i   = ($urandom_range(7) == 0);
      xfer_start_i = ($urandom_range(11) == 0);
      xfer_done_i  = ($urandom_range(11) == 0);
      dma_bound_i  = ($urandom_range(3) == 0);
      gap_stop_i   = ($urandom_range(5) == 0);
      if ($urandom_range(3) == 0) w1c(9'($urandom));
      if ($urandom_range(31) == 0) stat_en_i = 9'($urandom) | 9'h0F0;
      if ($urandom_range(31) == 0) stat_en_i = '1;
      if ($urandom_range(15) == 0) sig_en_i = 9'($urandom);
      tick();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule